// File: doc/BRIEF.md
# CAN Bus Integration Idle Detector

This block watches the sampled receive line of a CAN node while the node is integrating onto the bus, and decides when the bus has gone idle so that the node may join traffic. It is driven by two strobes from an external bit-timing unit: one pulse per time quantum (TQ) and one pulse at each nominal sample point. It runs only between an integration request and the moment the bus is judged idle.

At each sample point a recessive level advances a counter of recessive bits. Once `IDLE_BITS` (default 11) recessive bits have been counted, the idle flag is raised and held. Each synchronizing edge (a move from recessive to dominant) restarts the count and is reported as a one-cycle hard-synchronization pulse. An optional edge filter accepts an edge only after `FILT_TQ` (default 2) consecutive dominant quanta. Shorter dominant glitches, such as fast data-phase bits, are then ignored: they neither resynchronize the node nor disturb the count. When the filter is disabled, a single dominant quantum after a recessive one counts as an edge.

Top module: `can_integ_idle`

## Requirements
- R1: After an integration request, `bus_idle_o` rises within two clock cycles of the sample-point strobe on which the `IDLE_BITS`-th recessive level (rx_i = 1) is counted. No earlier sample point raises it.
- R2: With filtering on (`filt_dis_i` = 0), a synchronizing edge is accepted on the TQ strobe of the second consecutive dominant (rx_i = 0) quantum that follows a recessive quantum.
- R3: With filtering on, a dominant run of a single quantum between recessive quanta produces no hard-sync pulse and leaves the recessive-bit count unchanged.
- R4: An accepted synchronizing edge restarts the recessive-bit count from zero.
- R5: With filtering off (`filt_dis_i` = 1), a single dominant quantum that follows a recessive quantum is accepted as a synchronizing edge.
- R6: `hard_sync_o` is high only during a cycle with `tq_tick_i` high. It is asserted for exactly one such cycle per dominant run.
- R7: An edge is recognized only if the previous quantum was recessive. Dominant quanta seen right after an integration request, with no recessive quantum before them, give no hard-sync pulse.
- R8: `bus_idle_o` stays high until the next `integ_start_i`. That request clears it on the following cycle and restarts counting and filtering.
- R9: Asynchronous active-low reset clears the idle flag, the counter and the filter state. Until a request arrives, no hard-sync pulse is issued.
- R10: No hard-sync pulse is issued while the block is not integrating, including after idle has been reached.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tq_tick_i | input | 1 | One-cycle strobe per time quantum |
| sample_tick_i | input | 1 | One-cycle strobe at the nominal sample point |
| rx_i | input | 1 | Sampled bus level, 1 = recessive |
| filt_dis_i | input | 1 | 1 disables the dominant-glitch edge filter |
| integ_start_i | input | 1 | Starts a new integration |
| bus_idle_o | output | 1 | Bus declared idle, sticky |
| hard_sync_o | output | 1 | Hard-synchronization pulse, same cycle as the qualifying TQ |

## Verification
The bench drives whole bits as patterns of eight quanta, with the sample point on the sixth, so that a glitch or a dominant pair can be placed at an exact quantum. A single-quantum glitch placed in the middle of a recessive run must leave the idle count unchanged. A filter that syncs on the first dominant quantum, or a counter cleared by the glitch, would raise idle one run too late or pulse at the wrong place. The checks record the exact quantum of each pulse, so an edge accepted one quantum early or late is reported. They also probe the off-by-one at the eleventh bit, a dominant start right after a request (a missing "previous recessive" test would sync there), and the sticky idle flag, which a design that kept its edge logic live would break with pulses after idle.

// File: rtl/can_integ_pkg.sv
package can_integ_pkg;
  localparam int unsigned DEF_IDLE_BITS = 11;
  localparam int unsigned DEF_FILT_TQ   = 2;

  typedef enum logic [1:0] {
    INTEG_OFF  = 2'd0,
    INTEG_RUN  = 2'd1,
    INTEG_IDLE = 2'd2
  } integ_state_e;
endpackage

// File: rtl/can_integ_edge_qual.sv
module can_integ_edge_qual #(
  parameter int unsigned FILT_TQ = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic tq_i,
  input  logic rx_i,
  input  logic filt_dis_i,
  output logic sync_o
);
  localparam int unsigned RW = $clog2(FILT_TQ + 1);

  logic          armed_q;   // a recessive quantum precedes the current dominant run
  logic [RW-1:0] dom_run_q;
  int unsigned   need;

  always_comb begin
    need   = filt_dis_i ? 1 : FILT_TQ;
    sync_o = tq_i && !rx_i && armed_q && ((int'(dom_run_q) + 1) >= need);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q   <= 1'b0;
      dom_run_q <= '0;
    end else if (clr_i) begin
      armed_q   <= 1'b0;
      dom_run_q <= '0;
    end else if (tq_i) begin
      if (rx_i) begin
        armed_q   <= 1'b1;
        dom_run_q <= '0;
      end else begin
        if (int'(dom_run_q) < FILT_TQ) dom_run_q <= dom_run_q + 1'b1;
        if (sync_o) armed_q <= 1'b0;
      end
    end
  end

  AST_SYNC_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_o |=> !sync_o); // R6
  AST_SYNC_AFTER_REC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !sync_o); // R7
endmodule

// File: rtl/can_integ_idle_cnt.sv
module can_integ_idle_cnt #(
  parameter int unsigned IDLE_BITS = 11
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic sync_i,
  input  logic smp_i,
  input  logic rx_i,
  output logic done_o
);
  localparam int unsigned CW = $clog2(IDLE_BITS + 1);

  logic [CW-1:0] cnt_q;

  assign done_o = (int'(cnt_q) == IDLE_BITS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_q <= '0;
    else if (clr_i || sync_i)           cnt_q <= '0;
    else if (smp_i && rx_i && !done_o)  cnt_q <= cnt_q + 1'b1;
  end

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(cnt_q) <= IDLE_BITS); // R1
  AST_SYNC_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_i |=> cnt_q == '0); // R4
endmodule

// File: rtl/can_integ_idle.sv
module can_integ_idle
  import can_integ_pkg::*;
#(
  parameter int unsigned IDLE_BITS = DEF_IDLE_BITS,
  parameter int unsigned FILT_TQ   = DEF_FILT_TQ
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tq_tick_i,
  input  logic sample_tick_i,
  input  logic rx_i,
  input  logic filt_dis_i,
  input  logic integ_start_i,
  output logic bus_idle_o,
  output logic hard_sync_o
);
  integ_state_e state_q;
  logic         running;
  logic         edge_sync;
  logic         cnt_done;

  assign running     = (state_q == INTEG_RUN) && !integ_start_i;
  assign hard_sync_o = running && edge_sync;
  assign bus_idle_o  = (state_q == INTEG_IDLE);

  can_integ_edge_qual #(.FILT_TQ(FILT_TQ)) u_edge (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (integ_start_i),
    .tq_i       (tq_tick_i && (state_q == INTEG_RUN)),
    .rx_i       (rx_i),
    .filt_dis_i (filt_dis_i),
    .sync_o     (edge_sync)
  );

  can_integ_idle_cnt #(.IDLE_BITS(IDLE_BITS)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (integ_start_i),
    .sync_i (hard_sync_o),
    .smp_i  (sample_tick_i && running),
    .rx_i   (rx_i),
    .done_o (cnt_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                state_q <= INTEG_OFF;
    else if (integ_start_i)                     state_q <= INTEG_RUN;
    else if (state_q == INTEG_RUN && cnt_done)  state_q <= INTEG_IDLE;
  end

  AST_SYNC_ON_TQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hard_sync_o |-> tq_tick_i); // R6
  AST_SYNC_DOMINANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hard_sync_o |-> !rx_i); // R2
  AST_NO_SYNC_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_idle_o |-> !hard_sync_o); // R10
  AST_IDLE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_idle_o && !integ_start_i |=> bus_idle_o); // R8
  AST_START_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    integ_start_i |=> !bus_idle_o); // R8
endmodule

// File: tb/can_integ_idle_tb.sv
`timescale 1ns/1ps
module can_integ_idle_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tq = 1'b0, smp = 1'b0, rx = 1'b1, fdis = 1'b0, start = 1'b0;
  logic idle, hsync;
  int   n_chk = 0, n_err = 0;
  logic [7:0] mask;
  int   pulses;

  always #5 clk = ~clk;

  can_integ_idle u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tq_tick_i(tq), .sample_tick_i(smp),
    .rx_i(rx), .filt_dis_i(fdis), .integ_start_i(start),
    .bus_idle_o(idle), .hard_sync_o(hsync)
  );

  task automatic chk(input int act, input int exp, input string req);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_start(input logic lvl);
    @(negedge clk); start = 1'b1; rx = lvl; tq = 1'b0; smp = 1'b0;
    @(negedge clk); start = 1'b0;
  endtask

  // one bit = 8 quanta, pattern bit t is the level of quantum t, sample on t=5
  task automatic send_bit(input logic [7:0] pat);
    mask = '0;
    for (int t = 0; t < 8; t++) begin
      @(negedge clk);
      rx = pat[t]; tq = 1'b1; smp = (t == 5);
      #1;
      mask[t] = hsync;
      if (hsync) pulses++;
    end
    @(negedge clk); tq = 1'b0; smp = 1'b0; rx = 1'b1;
  endtask

  task automatic send_rec(input int n);
    for (int i = 0; i < n; i++) send_bit(8'hFF);
  endtask

  task automatic t_reset;
    #1;
    chk(idle, 0, "R9 idle in reset");
    chk(hsync, 0, "R9 sync in reset");
    @(negedge clk); rst_n = 1'b1;
    pulses = 0;
    send_bit(8'hF9);
    chk(pulses, 0, "R9 no sync before request");
    chk(idle, 0, "R9 idle before request");
  endtask

  task automatic t_eleven;
    fdis = 1'b0; do_start(1'b1); pulses = 0;
    send_rec(10);
    chk(idle, 0, "R1 not idle after 10 bits");
    send_bit(8'hFF);
    chk(idle, 1, "R1 idle after 11 bits");
    chk(pulses, 0, "R1 no sync on recessive bus");
  endtask

  task automatic t_glitch;
    fdis = 1'b0; do_start(1'b1); pulses = 0;
    send_rec(5);
    send_bit(8'hFB);
    chk(mask, 0, "R3 one-quantum glitch gives no sync");
    send_rec(4);
    chk(idle, 0, "R3 count before last bit");
    send_bit(8'hFF);
    chk(idle, 1, "R3 glitch left count intact");
  endtask

  task automatic t_filter_pair;
    fdis = 1'b0; do_start(1'b1); pulses = 0;
    send_rec(8);
    send_bit(8'hF9);
    chk(mask, 8'h04, "R2 sync on second dominant quantum");
    chk(pulses, 1, "R6 one pulse per dominant run");
    send_rec(9);
    chk(idle, 0, "R4 count restarted by sync");
    send_bit(8'hFF);
    chk(idle, 1, "R4 idle after restart");
  endtask

  task automatic t_unfiltered;
    fdis = 1'b1; do_start(1'b1); pulses = 0;
    send_rec(3);
    send_bit(8'hFB);
    chk(mask, 8'h04, "R5 single dominant quantum syncs");
    send_bit(8'hF1);
    chk(mask, 8'h02, "R6 single pulse on long dominant run");
  endtask

  task automatic t_no_prev_rec;
    fdis = 1'b1; do_start(1'b0); pulses = 0;
    send_bit(8'h00);
    chk(mask, 0, "R7 dominant after request is no edge");
    send_bit(8'hFE);
    chk(mask, 0, "R7 still within dominant run");
    send_bit(8'hFE);
    chk(mask, 8'h01, "R7 edge after recessive quantum");
  endtask

  task automatic t_sticky;
    fdis = 1'b1; do_start(1'b1);
    send_rec(11);
    chk(idle, 1, "R8 idle reached");
    send_bit(8'hFA);
    chk(mask, 0, "R10 no sync while idle");
    chk(idle, 1, "R8 idle sticky on dominant");
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(idle, 0, "R8 request clears idle");
  endtask

  initial begin
    t_reset;
    t_eleven;
    t_glitch;
    t_filter_pair;
    t_unfiltered;
    t_no_prev_rec;
    t_sticky;
    $display("%0d/%0d checks passed", n_chk - n_err, n_chk);
    $finish;
  end

  initial begin
    #1_000_000;
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_err, n_chk);
    $finish;
  end
endmodule